// File: doc/BRIEF.md
# Handshaked Serial Command Receiver

This block takes command and coefficient bytes from a host controller over a slow synchronous serial link. The link has a data line and a clock line, plus two handshake lines. The host raises a request line to open a transfer. The receiver answers with a busy acknowledge that stays high while the transfer is open. The host then clocks in one or more 8-bit bytes. It closes the transfer with a pulse on a separate ready line. The receiver does not look at the meaning of the bytes.

All four host lines are asynchronous to the fast system clock. Each passes through a multi-stage synchronizer, and edges are detected on the synchronized copies. This is safe because every serial clock phase and every ready pulse spans several system clocks. Data is captured on the rising serial clock edge, most significant bit first. Each completed byte is presented for one cycle, together with its position in the transfer and a flag that marks the first byte. If the transfer is closed in the middle of a byte, the partial bits are dropped and an error flag is raised.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `busy_ack`, `byte_valid`, `first_byte` and `frame_err` are 0, and `byte_index` is 0.
- R2: A rising edge on `host_req` while no transfer is open raises `busy_ack` within SYNC_STAGES+3 system clocks.
- R3: While `busy_ack` is high, each rising edge of `host_sclk` captures `host_sdat`. The first captured bit becomes bit 7 of the byte and the eighth becomes bit 0. Every 8 captured bits produce exactly one `byte_valid` with that value on `byte_data`.
- R4: `byte_index` counts the bytes of a transfer from 0 in steps of 1. It wraps to 0 after 2^IDX_W-1.
- R5: `first_byte` is 1 together with the first `byte_valid` of a transfer and 0 with every later one.
- R6: A rising edge on `host_rdy` while a transfer is open drops `busy_ack` to 0.
- R7: If `host_rdy` closes a transfer with a bit count that is not a multiple of 8, the partial bits produce no `byte_valid` and `frame_err` becomes 1. `frame_err` stays 1 until the next transfer opens, which clears it.
- R8: `host_sclk` edges while no transfer is open are ignored. They produce no `byte_valid`, and the next transfer starts with an empty bit count.
- R9: A transfer closed after a whole number of bytes leaves `frame_err` at 0.
- R10: `byte_valid` is never high for two consecutive cycles and is only high while `busy_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request to open a transfer (asynchronous) |
| host_sdat | input | 1 | Serial data from host (asynchronous) |
| host_sclk | input | 1 | Serial clock from host (asynchronous) |
| host_rdy | input | 1 | Host ready pulse that closes a transfer (asynchronous) |
| busy_ack | output | 1 | High while a transfer is open |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte, valid with `byte_valid` |
| byte_index | output | IDX_W | Position of the byte within the transfer |
| first_byte | output | 1 | Marks the first byte of a transfer |
| frame_err | output | 1 | Last transfer ended on a partial byte |

## Verification
The bench builds the receiver with SYNC_STAGES=3 and IDX_W=3. The deeper synchronizer stretches the input latency, so the bench's host timing has to tolerate it. The narrow index counter means that transfers of nine or more bytes reach the index wrap from 7 back to 0. Random transfers of 1 to 11 bytes, some ending with 1 to 7 stray bits, cover both the clean close and the partial close. Directed cases cover serial clocks sent outside a transfer and the clearing of a sticky error when the next transfer opens.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W);

    typedef enum logic [0:0] {
        LINK_IDLE = 1'b0,
        LINK_OPEN = 1'b1
    } link_state_t;

    // Host line bundle, in a fixed order for the synchronizer vector.
    typedef struct packed {
        logic req;
        logic sdat;
        logic sclk;
        logic rdy;
    } host_lines_t;

    localparam int HOST_W = $bits(host_lines_t);

    // A byte leaving the shifter.
    typedef struct packed {
        logic              done;
        logic [BYTE_W-1:0] value;
    } shift_out_t;

    function automatic logic [BYTE_W-1:0] shift_in_msb(
        input logic [BYTE_W-1:0] cur,
        input logic              bit_in
    );
        return {cur[BYTE_W-2:0], bit_in};
    endfunction

    function automatic logic count_is_last(input logic [BCNT_W-1:0] cnt);
        return cnt == BCNT_W'(BYTE_W - 1);
    endfunction
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/scr_edge.sv
module scr_edge #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign rise[b] = level[b] & ~prev_q[b];
        end
    endgenerate
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample_en,
    input  logic       bit_in,
    output shift_out_t out,
    output logic       partial
);
    logic [BYTE_W-1:0] shreg_q;
    logic [BCNT_W-1:0] cnt_q;
    logic [BYTE_W-1:0] next_val;

    assign next_val = shift_in_msb(shreg_q, bit_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q   <= '0;
            cnt_q     <= '0;
            out.done  <= 1'b0;
            out.value <= '0;
        end else begin
            out.done <= 1'b0;
            if (clear) begin
                cnt_q   <= '0;
                shreg_q <= '0;
            end else if (sample_en) begin
                shreg_q <= next_val;
                if (count_is_last(cnt_q)) begin
                    cnt_q     <= '0;
                    out.done  <= 1'b1;
                    out.value <= next_val;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign partial = (cnt_q != '0);
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
    import scr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rise,
    input  logic              rdy_rise,
    input  logic              sclk_rise,
    input  shift_out_t        shin,
    input  logic              partial,
    output logic              shift_clear,
    output logic              sample_en,
    output logic              busy_ack,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic [IDX_W-1:0]  byte_index,
    output logic              first_byte,
    output logic              frame_err
);
    link_state_t      state_q;
    logic [IDX_W-1:0] idx_q;
    logic             any_byte_q;
    logic             open_now;
    logic             close_now;

    assign open_now    = (state_q == LINK_IDLE) && req_rise;
    assign close_now   = (state_q == LINK_OPEN) && rdy_rise;
    assign shift_clear = open_now || close_now;
    assign sample_en   = (state_q == LINK_OPEN) && sclk_rise && !rdy_rise;
    assign busy_ack    = (state_q == LINK_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= LINK_IDLE;
            idx_q      <= '0;
            any_byte_q <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            if (open_now) begin
                state_q    <= LINK_OPEN;
                idx_q      <= '0;
                any_byte_q <= 1'b0;
                frame_err  <= 1'b0;
            end else if (close_now) begin
                state_q   <= LINK_IDLE;
                frame_err <= partial;
            end else if (shin.done && state_q == LINK_OPEN) begin
                idx_q      <= idx_q + 1'b1;
                any_byte_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_index <= '0;
            first_byte <= 1'b0;
        end else begin
            byte_valid <= shin.done && (state_q == LINK_OPEN) && !close_now;
            if (shin.done && state_q == LINK_OPEN) begin
                byte_data  <= shin.value;
                byte_index <= idx_q;
                first_byte <= !any_byte_q;
            end
        end
    end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_sdat,
    input  logic              host_sclk,
    input  logic              host_rdy,
    output logic              busy_ack,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic [IDX_W-1:0]  byte_index,
    output logic              first_byte,
    output logic              frame_err
);
    host_lines_t raw_lines;
    host_lines_t sync_lines;
    host_lines_t rise_lines;
    shift_out_t  shin;
    logic        shift_clear;
    logic        sample_en;
    logic        partial;

    assign raw_lines = '{req: host_req, sdat: host_sdat, sclk: host_sclk, rdy: host_rdy};

    scr_sync #(.WIDTH(HOST_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    scr_edge #(.WIDTH(HOST_W)) i_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sync_lines),
        .rise  (rise_lines)
    );

    scr_shifter i_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (shift_clear),
        .sample_en (sample_en),
        .bit_in    (sync_lines.sdat),
        .out       (shin),
        .partial   (partial)
    );

    scr_ctrl #(.IDX_W(IDX_W)) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_rise    (rise_lines.req),
        .rdy_rise    (rise_lines.rdy),
        .sclk_rise   (rise_lines.sclk),
        .shin        (shin),
        .partial     (partial),
        .shift_clear (shift_clear),
        .sample_en   (sample_en),
        .busy_ack    (busy_ack),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_index  (byte_index),
        .first_byte  (first_byte),
        .frame_err   (frame_err)
    );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_ack,
    input logic             byte_valid,
    input logic [IDX_W-1:0] byte_index,
    input logic             first_byte,
    input logic             frame_err
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) byte_valid |=> !byte_valid); // R10
    AST_VALID_IN_XFER: assert property (@(posedge clk) disable iff (rst) byte_valid |-> busy_ack); // R10
    AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (rst) (byte_valid && first_byte) |-> (byte_index == '0)); // R5
    AST_ERR_ON_CLOSE: assert property (@(posedge clk) disable iff (rst) $rose(frame_err) |-> $fell(busy_ack)); // R7
    AST_ERR_CLEAR_ON_OPEN: assert property (@(posedge clk) disable iff (rst) $rose(busy_ack) |-> !frame_err); // R7
    AST_ERR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!busy_ack && !$rose(busy_ack) && $past(!busy_ack)) |-> $stable(frame_err)); // R7
endmodule

bind serial_cmd_rx scr_checker #(.IDX_W(IDX_W)) i_scr_checker (
    .clk        (clk),
    .rst        (rst),
    .busy_ack   (busy_ack),
    .byte_valid (byte_valid),
    .byte_index (byte_index),
    .first_byte (first_byte),
    .frame_err  (frame_err)
);

// File: tb/test_serial_cmd_rx.sv
module test_serial_cmd_rx;
    localparam int SYNC_STAGES = 3;
    localparam int IDX_W       = 3;
    localparam int PH          = 6;   // system clocks per serial phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0, host_sdat = 1'b0, host_sclk = 1'b0, host_rdy = 1'b0;
    logic busy_ack, byte_valid, first_byte, frame_err;
    logic [7:0] byte_data;
    logic [IDX_W-1:0] byte_index;

    int total = 0;
    int bad = 0;

    logic [7:0]       got_data  [0:31];
    logic [IDX_W-1:0] got_idx   [0:31];
    logic             got_first [0:31];
    int               got_n = 0;
    int               dbl_valid = 0;
    logic             prev_valid = 1'b0;
    logic [7:0]       exp_b [0:31];

    always #4 clk = ~clk;

    serial_cmd_rx #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) i_serial_cmd_rx (
        .clk(clk), .rst(rst), .host_req(host_req), .host_sdat(host_sdat),
        .host_sclk(host_sclk), .host_rdy(host_rdy), .busy_ack(busy_ack),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_index(byte_index),
        .first_byte(first_byte), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (byte_valid && got_n < 32) begin
            got_data[got_n]  = byte_data;
            got_idx[got_n]   = byte_index;
            got_first[got_n] = first_byte;
            got_n++;
        end
        if (byte_valid && prev_valid) dbl_valid++;
        prev_valid = byte_valid;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        host_sdat = b;
        wait_clk(PH);
        host_sclk = 1'b1;
        wait_clk(PH);
        host_sclk = 1'b0;
    endtask

    function automatic logic [IDX_W-1:0] exp_index(input int k);
        return IDX_W'(k % (1 << IDX_W));
    endfunction

    task automatic run_transfer(input int nbytes, input int extra);
        got_n = 0;
        host_req = 1'b1;
        wait_clk(SYNC_STAGES + 3);
        check("R2 ack after request", busy_ack, 1'b1);
        check("R7 error cleared at open", frame_err, 1'b0);
        host_req = 1'b0;
        for (int k = 0; k < nbytes; k++) begin
            exp_b[k] = 8'($urandom);
            for (int b = 7; b >= 0; b--) send_bit(exp_b[k][b]);
        end
        for (int e = 0; e < extra; e++) send_bit(1'($urandom));
        wait_clk(PH);
        host_rdy = 1'b1;
        wait_clk(2 * PH);
        host_rdy = 1'b0;
        wait_clk(PH);
        check("R6 ack low after ready", busy_ack, 1'b0);
        if (extra != 0) check("R7 error on partial", frame_err, 1'b1);
        else            check("R9 no error on whole bytes", frame_err, 1'b0);
        check("R3 R7 byte count", got_n, nbytes);
        for (int k = 0; k < nbytes && k < got_n; k++) begin
            check("R3 byte value", got_data[k], exp_b[k]);
            check("R4 byte index", got_idx[k], exp_index(k));
            check("R5 first flag", got_first[k], (k == 0));
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        check("R1 ack reset", busy_ack, 1'b0);
        check("R1 valid reset", byte_valid, 1'b0);
        check("R1 first reset", first_byte, 1'b0);
        check("R1 err reset", frame_err, 1'b0);
        check("R1 index reset", byte_index, 0);

        // directed: exact single byte, MSB first
        got_n = 0;
        run_transfer(1, 0);
        // directed: partial then sticky, then cleared by next open
        run_transfer(2, 3);
        wait_clk(20);
        check("R7 error held while idle", frame_err, 1'b1);
        // directed: stray clocks while idle
        got_n = 0;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        wait_clk(PH);
        check("R8 no strobe when idle", got_n, 0);
        check("R8 ack stays low", busy_ack, 1'b0);
        run_transfer(2, 0);
        // directed: index wrap
        run_transfer(10, 0);
        // random mix
        for (int t = 0; t < 12; t++) begin
            int nb = 1 + int'($urandom % 11);
            int ex = (($urandom % 3) == 0) ? 1 + int'($urandom % 7) : 0;
            run_transfer(nb, ex);
        end
        check("R10 single-cycle strobe", dbl_valid, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule